// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small processor subsystem may drop its clocks or its power, and brings it back. Software writes a configuration register that holds a target mode, a choice of how much extra SRAM to keep alive, and an option that turns off watching of the external supply. Nothing powers down when that register is written. The sequencer acts only when the core raises its wait-for-interrupt request. It then moves into one of two low-power states. In the light state only the core clock stops, while peripherals, memories and DMA keep running. In the deep state the core and peripherals are powered off and only the selected SRAM banks are retained.

Any wake event returns the block to the fully active state. While it is in the deep state, the block watches two supply comparator flags. One flag is for the regulated core rail and is always watched. The other is for the external supply and can be switched off by software. A fault on a watched rail produces a single-cycle chip reset request, and the sequencer returns to active at the same time, before retained data could be lost. A debug hold latch can veto every low-power entry. Only the block's power-on reset clears that latch.

Top module: `lpm_sequencer`

## Requirements
- R1: After power-on reset the state code is 0 (active). Core clock, peripheral clock and peripheral power enables are 1. All retention enables and the reset request are 0. The configuration readback is 0.
- R2: A write stores the mode in bits [1:0], the external-monitor-off flag in bit 3 and the retention select in bits [5:4]. A read returns exactly these fields, and every other bit reads as 0.
- R3: In active state with mode 1 and no debug hold, a wait-for-interrupt request moves the block to state code 1 at the next edge. There the core clock enable is 0, and the peripheral clock and power enables stay 1.
- R4: Writing a mode value without a wait-for-interrupt request leaves the block in the active state.
- R5: In active state with mode 2 and no debug hold, a wait-for-interrupt request moves the block to state code 2 at the next edge. There the core clock, peripheral clock and peripheral power enables are 0, and the base bank retention enable is 1.
- R6: In state 2 the three extra-bank retention enables form a thermometer code of the retention select captured at entry: 00 gives 000, 01 gives 001, 10 gives 011 and 11 gives 111. Writes made during state 2 do not change them.
- R7: A wake event in state 1 or state 2 returns the block to state 0 at the next edge.
- R8: In state 2 a low regulated-core flag produces a chip reset request for exactly one cycle, and in that same cycle the state is 0. In states 0 and 1 the flag has no effect.
- R9: In state 2 a low external-supply flag acts like R8 only when the external-monitor-off bit is 0. When that bit is 1 the flag is ignored.
- R10: Once the debug hold input has been seen high, no wait-for-interrupt request causes any low-power entry until the next power-on reset.
- R11: Mode values 0 and 3 behave as active: a wait-for-interrupt request leaves the block in state 0.
- R12: In state 2 a supply fault takes priority over a simultaneous wake, so the reset request is still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| wfi_req | input | 1 | Wait-for-interrupt request from the core |
| dbg_hold_set | input | 1 | Sets the debug hold latch |
| wake_evt | input | 1 | Wake event |
| vreg_low | input | 1 | Regulated core rail below retention threshold |
| vext_low | input | 1 | External supply below limit |
| cur_mode | output | 2 | Current state code: 0 active, 1 core sleep, 2 hibernate |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral, memory and DMA clock enable |
| periph_pwr_en | output | 1 | Peripheral power enable |
| sram_base_ret | output | 1 | Base SRAM bank retention enable |
| sram_extra_ret | output | 3 | Extra SRAM bank retention enables |
| chip_rst_req | output | 1 | Single-cycle chip reset request |

## Verification
Directed sequences step through every target mode together with a wait-for-interrupt request. Comparing mode 1, mode 2 and the reserved values separates light entry, deep entry and the fall-through to active. The deep state is entered with each retention select, and writes made while in the deep state show whether the captured value holds. Fault flags are raised in each state and under both monitor settings, alone and together with wake, to show where the reset request comes from and how it ranks against wake. Thousands of seeded random cycles then mix writes, requests, wakes and faults against a reference model kept in the bench.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int RET_W       = 2;
  localparam int EXTRA_BANKS = (1 << RET_W) - 1;
  localparam int MODE_W      = 2;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_HIBER  = 2'd2
  } pm_state_e;

  localparam logic [MODE_W-1:0] MODE_SLEEP = 2'd1;
  localparam logic [MODE_W-1:0] MODE_HIBER = 2'd2;

  // Count of extra banks kept alive becomes a thermometer vector
  function automatic logic [EXTRA_BANKS-1:0] ret_thermo(input logic [RET_W-1:0] sel);
    logic [EXTRA_BANKS-1:0] t;
    for (int i = 0; i < EXTRA_BANKS; i++) t[i] = (int'(sel) > i);
    return t;
  endfunction
endpackage

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs
  import lpm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dbg_set,
  output logic [MODE_W-1:0] mode,
  output logic              mon_off,
  output logic [RET_W-1:0]  ret_sel,
  output logic              dbg_latched,
  output logic [DATA_W-1:0] rdata
);
  localparam int MODE_LSB = 0;
  localparam int MON_BIT  = 3;
  localparam int RET_LSB  = 4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      mon_off <= 1'b0;
      ret_sel <= '0;
    end else if (we) begin
      mode    <= wdata[MODE_LSB +: MODE_W];
      mon_off <= wdata[MON_BIT];
      ret_sel <= wdata[RET_LSB +: RET_W];
    end
  end

  // Debug hold: sticky until power-on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dbg_latched <= 1'b0;
    else if (dbg_set) dbg_latched <= 1'b1;
  end

  always_comb begin
    rdata = '0;
    rdata[MODE_LSB +: MODE_W] = mode;
    rdata[MON_BIT]            = mon_off;
    rdata[RET_LSB +: RET_W]   = ret_sel;
  end

  a_r10_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_latched |=> dbg_latched);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[MODE_LSB +: MODE_W] == $past(wdata[MODE_LSB +: MODE_W])));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              mon_off,
  input  logic [RET_W-1:0]  ret_sel,
  input  logic              dbg_latched,
  input  logic              wfi_req,
  input  logic              wake_evt,
  input  logic              vreg_low,
  input  logic              vext_low,
  output pm_state_e         state,
  output logic [RET_W-1:0]  hib_ret,
  output logic              rst_pulse
);
  pm_state_e state_nx;
  logic enter_sleep, enter_hib, supply_fault, wake_exit;

  assign enter_sleep  = (state == PM_ACTIVE) && wfi_req && !dbg_latched && (mode == MODE_SLEEP);
  assign enter_hib    = (state == PM_ACTIVE) && wfi_req && !dbg_latched && (mode == MODE_HIBER);
  assign supply_fault = (state == PM_HIBER) && (vreg_low || (vext_low && !mon_off));
  assign wake_exit    = (state != PM_ACTIVE) && wake_evt && !supply_fault;

  always_comb begin
    state_nx = state;
    if (enter_sleep)                  state_nx = PM_SLEEP;
    else if (enter_hib)               state_nx = PM_HIBER;
    else if (supply_fault || wake_exit) state_nx = PM_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PM_ACTIVE;
      hib_ret   <= '0;
      rst_pulse <= 1'b0;
    end else begin
      state     <= state_nx;
      rst_pulse <= supply_fault;
      if (enter_hib) hib_ret <= ret_sel;
    end
  end

  a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_ACTIVE && wfi_req && !dbg_latched && mode == MODE_SLEEP) |=> state == PM_SLEEP);
  a_r4_no_entry_without_wfi: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_ACTIVE && !wfi_req) |=> state == PM_ACTIVE);
  a_r7_wake_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PM_ACTIVE && wake_evt) |=> state == PM_ACTIVE);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  a_r8_pulse_from_hib: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (state == PM_ACTIVE && $past(state) == PM_HIBER));
  a_r10_veto: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_latched && state == PM_ACTIVE) |=> state == PM_ACTIVE);
  a_r6_ret_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_HIBER) |=> $stable(hib_ret));
endmodule

// File: rtl/lpm_out_map.sv
module lpm_out_map
  import lpm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  pm_state_e              state,
  input  logic [RET_W-1:0]       hib_ret,
  output logic                   core_clk_en,
  output logic                   periph_clk_en,
  output logic                   periph_pwr_en,
  output logic                   sram_base_ret,
  output logic [EXTRA_BANKS-1:0] sram_extra_ret
);
  logic in_hib;
  assign in_hib = (state == PM_HIBER);

  assign core_clk_en   = (state == PM_ACTIVE);
  assign periph_clk_en = !in_hib;
  assign periph_pwr_en = !in_hib;
  assign sram_base_ret = in_hib;

  for (genvar g = 0; g < EXTRA_BANKS; g++) begin : g_bank
    logic thermo_bit;
    assign thermo_bit        = ret_thermo(hib_ret)[g];
    assign sram_extra_ret[g] = in_hib && thermo_bit;
  end

  a_r6_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    in_hib |-> ($countones(sram_extra_ret) == int'(hib_ret)));
  a_r5_retain_only_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_extra_ret != '0) |-> (sram_base_ret && !periph_pwr_en));
  a_r3_core_gated_first: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> periph_clk_en);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              wfi_req,
  input  logic              dbg_hold_set,
  input  logic              wake_evt,
  input  logic              vreg_low,
  input  logic              vext_low,
  output logic [1:0]        cur_mode,
  output logic              core_clk_en,
  output logic              periph_clk_en,
  output logic              periph_pwr_en,
  output logic              sram_base_ret,
  output logic [2:0]        sram_extra_ret,
  output logic              chip_rst_req
);
  logic [MODE_W-1:0] mode;
  logic              mon_off;
  logic [RET_W-1:0]  ret_sel;
  logic              dbg_latched;
  pm_state_e         state;
  logic [RET_W-1:0]  hib_ret;

  lpm_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .dbg_set(dbg_hold_set),
    .mode(mode), .mon_off(mon_off), .ret_sel(ret_sel), .dbg_latched(dbg_latched),
    .rdata(cfg_rdata)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mon_off(mon_off), .ret_sel(ret_sel),
    .dbg_latched(dbg_latched), .wfi_req(wfi_req), .wake_evt(wake_evt),
    .vreg_low(vreg_low), .vext_low(vext_low), .state(state), .hib_ret(hib_ret),
    .rst_pulse(chip_rst_req)
  );

  lpm_out_map u_map (
    .clk(clk), .rst_n(rst_n), .state(state), .hib_ret(hib_ret),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .periph_pwr_en(periph_pwr_en), .sram_base_ret(sram_base_ret),
    .sram_extra_ret(sram_extra_ret)
  );

  assign cur_mode = state;

  a_r1_rst_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_req |-> (core_clk_en && periph_pwr_en));
endmodule

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic wfi_req = 1'b0, dbg_hold_set = 1'b0, wake_evt = 1'b0, vreg_low = 1'b0, vext_low = 1'b0;
  logic [1:0] cur_mode;
  logic core_clk_en, periph_clk_en, periph_pwr_en, sram_base_ret, chip_rst_req;
  logic [2:0] sram_extra_ret;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model
  int m_state, m_mode, m_ret, m_hret;
  bit m_mon_off, m_dbg, m_rst;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_sequencer u_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wfi_req(wfi_req), .dbg_hold_set(dbg_hold_set), .wake_evt(wake_evt),
    .vreg_low(vreg_low), .vext_low(vext_low), .cur_mode(cur_mode),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .periph_pwr_en(periph_pwr_en),
    .sram_base_ret(sram_base_ret), .sram_extra_ret(sram_extra_ret), .chip_rst_req(chip_rst_req)
  );

  function automatic logic [2:0] exp_extra(int st, int hr);
    case (hr)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [7:0] exp_rdata();
    return {2'b00, 2'(m_ret), m_mon_off, 1'b0, 2'(m_mode)};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "state", int'(cur_mode), m_state);
    chk(tag, "core_clk_en", int'(core_clk_en), int'(m_state == 0));
    chk(tag, "periph_clk_en", int'(periph_clk_en), int'(m_state != 2));
    chk(tag, "periph_pwr_en", int'(periph_pwr_en), int'(m_state != 2));
    chk(tag, "sram_base_ret", int'(sram_base_ret), int'(m_state == 2));
    chk(tag, "sram_extra_ret", int'(sram_extra_ret),
        (m_state == 2) ? int'(exp_extra(m_state, m_hret)) : 0);
    chk(tag, "chip_rst_req", int'(chip_rst_req), int'(m_rst));
    chk(tag, "cfg_rdata", int'(cfg_rdata), int'(exp_rdata()));
  endtask

  task automatic model_reset();
    m_state = 0; m_mode = 0; m_ret = 0; m_hret = 0;
    m_mon_off = 0; m_dbg = 0; m_rst = 0;
  endtask

  task automatic model_step(bit we, logic [7:0] wd, bit wfi, bit wk, bit vr, bit ve, bit dbg);
    int ns = m_state;
    bit nr = 0;
    case (m_state)
      0: if (wfi && !m_dbg) begin
           if (m_mode == 1) ns = 1;
           else if (m_mode == 2) begin ns = 2; m_hret = m_ret; end
         end
      1: if (wk) ns = 0;
      default: if (vr || (ve && !m_mon_off)) begin ns = 0; nr = 1; end
               else if (wk) ns = 0;
    endcase
    m_state = ns;
    m_rst = nr;
    if (we) begin
      m_mode = int'(wd[1:0]); m_mon_off = wd[3]; m_ret = int'(wd[5:4]);
    end
    if (dbg) m_dbg = 1;
  endtask

  task automatic step(string tag, bit we, logic [7:0] wd, bit wfi, bit wk, bit vr, bit ve, bit dbg);
    cfg_we = we; cfg_wdata = wd; wfi_req = wfi; wake_evt = wk;
    vreg_low = vr; vext_low = ve; dbg_hold_set = dbg;
    model_step(we, wd, wfi, wk, vr, ve, dbg);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 8'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    cfg_we = 0; wfi_req = 0; wake_evt = 0; vreg_low = 0; vext_low = 0; dbg_hold_set = 0;
    rst_n = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1c3a));
    @(negedge clk);
    do_reset();
    compare("R1_reset");

    // R2 register layout
    step("R2_write", 1, 8'hFB, 0, 0, 0, 0, 0);
    idle("R2_read");
    // R3 light sleep, R8 ignored outside hibernate, R7 wake
    step("R3_cfg", 1, 8'h01, 0, 0, 0, 0, 0);
    step("R3_enter", 0, 8'h00, 1, 0, 0, 0, 0);
    step("R8_ignored_sleep", 0, 8'h00, 0, 0, 1, 1, 0);
    step("R7_wake_sleep", 0, 8'h00, 0, 1, 0, 0, 0);
    step("R8_ignored_active", 0, 8'h00, 0, 0, 1, 1, 0);
    // R11 reserved and active modes
    step("R11_cfg3", 1, 8'h03, 0, 0, 0, 0, 0);
    step("R11_wfi3", 0, 8'h00, 1, 0, 0, 0, 0);
    step("R11_cfg0", 1, 8'h00, 0, 0, 0, 0, 0);
    step("R11_wfi0", 0, 8'h00, 1, 0, 0, 0, 0);
    // R4 write alone, R5 entry, R6 thermometer and freeze
    step("R4_cfg", 1, 8'h32, 0, 0, 0, 0, 0);
    idle("R4_stay");
    step("R5_enter", 0, 8'h00, 1, 0, 0, 0, 0);
    step("R6_write_in_hib", 1, 8'h02, 0, 0, 0, 0, 0);
    idle("R6_frozen");
    step("R7_wake_hib", 0, 8'h00, 0, 1, 0, 0, 0);
    // R9 external monitor enabled
    step("R9_cfg_on", 1, 8'h12, 0, 0, 0, 0, 0);
    step("R9_enter", 0, 8'h00, 1, 0, 0, 0, 0);
    step("R9_fault", 0, 8'h00, 0, 0, 0, 1, 0);
    idle("R8_pulse_end");
    // R9 external monitor disabled, R12 priority
    step("R9_cfg_off", 1, 8'h1A, 0, 0, 0, 0, 0);
    step("R9_enter_off", 0, 8'h00, 1, 0, 0, 0, 0);
    step("R9_ignored", 0, 8'h00, 0, 0, 0, 1, 0);
    step("R12_fault_wake", 0, 8'h00, 0, 1, 1, 0, 0);
    idle("R8_pulse_once");
    // R6 select 10
    step("R6_cfg2", 1, 8'h22, 0, 0, 0, 0, 0);
    step("R6_enter2", 0, 8'h00, 1, 0, 0, 0, 0);
    step("R7_wake2", 0, 8'h00, 0, 1, 0, 0, 0);
    // R10 debug hold
    step("R10_set", 1, 8'h01, 0, 0, 0, 0, 1);
    step("R10_veto_sleep", 0, 8'h00, 1, 0, 0, 0, 0);
    step("R10_cfg_hib", 1, 8'h02, 0, 0, 0, 0, 0);
    step("R10_veto_hib", 0, 8'h00, 1, 0, 0, 0, 0);
    step("R10_veto_again", 0, 8'h00, 1, 1, 0, 0, 0);
    do_reset();
    compare("R1_reset_again");
    step("R10_cleared_cfg", 1, 8'h01, 0, 0, 0, 0, 0);
    step("R10_cleared", 0, 8'h00, 1, 0, 0, 0, 0);
    step("R7_wake_after", 0, 8'h00, 0, 1, 0, 0, 0);

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      bit we, wfi, wk, vr, ve;
      logic [7:0] wd;
      we  = ($urandom % 8) == 0;
      wd  = 8'($urandom);
      wfi = ($urandom % 3) == 0;
      wk  = ($urandom % 9) == 0;
      vr  = ($urandom % 23) == 0;
      ve  = ($urandom % 13) == 0;
      step("random", we, wd, wfi, wk, vr, ve, 0);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule